// File: doc/BRIEF.md
# Hall Commutation Decoder with Direction

This block turns the three Hall-sensor logic levels of a three-phase brushless motor into six switch enables for the bridge: one high-side (source) and one low-side (sink) enable per phase. Each legal Hall code selects one phase to source current and one to sink it. A direction input reverses rotation by decoding the bitwise complement of the Hall code through the same forward table. The two Hall codes that cannot occur on a healthy sensor set switch everything off.

Drive gating follows a fixed priority. A stop request clears all six enables. A protection inhibit from the restraint monitor clears only the low side. The PWM gate from the chopper chops only the active low-side switch, and the high side stays fully on for the whole step. A current-limit flag ends the low-side on-time for the rest of the current PWM period. The direction input is resynchronised through a flip-flop chain before it reaches the decoder. All enables are registered, so the outputs change one clock edge after the inputs.

Top module: `hall_commutator`

## Requirements
- R1: With forward direction (`dir_rev`=0), Hall code {H1,H2,H3} = `hall_lvl[2:0]` selects source→sink phases: 101 → ph2→ph1, 100 → ph3→ph1, 110 → ph3→ph2, 010 → ph1→ph2, 011 → ph1→ph3, 001 → ph2→ph3. Phase n is bit n-1 of `hs_en` and `ls_en`.
- R2: With reverse direction (`dir_rev`=1), the block outputs the pair that R1 gives for the bitwise complement of the Hall code.
- R3: At most one high-side and at most one low-side enable is ever active. With a legal code, stop and inhibit low, the PWM gate high and no current limit, exactly one of each is active.
- R4: Hall codes 000 and 111 turn all six enables off in either direction.
- R5: `stop_req` high turns all six enables off. This takes effect one clock edge after it is sampled.
- R6: `fault_inh` high turns every low-side enable off. The high-side enable keeps its decoded value.
- R7: `pwm_gate` low turns the low-side enable off. The high-side enable is not affected.
- R8: If `ilim_active` is sampled high while `pwm_gate` is high, the low side is off from the next edge on, until `pwm_gate` has been sampled low. It stays off even after `ilim_active` falls.
- R9: A change on `dir_rev` passes through a two-stage synchroniser. The outputs reflect a new direction on the third clock edge after the change.
- R10: The high-side and low-side enables of the same phase are never active together.
- R11: While `rst_n` is low, all enables are 0 and the direction and current-limit state return to forward and clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hall_lvl | input | 3 | Debounced Hall levels {H1,H2,H3} |
| dir_rev | input | 1 | 0 forward, 1 reverse (asynchronous) |
| stop_req | input | 1 | 1 stops the drive |
| fault_inh | input | 1 | Restraint-protection inhibit of the low side |
| pwm_gate | input | 1 | PWM chop gate for the low side |
| ilim_active | input | 1 | Current-limit trip for the present PWM period |
| hs_en | output | 3 | High-side enables, bit n-1 = phase n |
| ls_en | output | 3 | Low-side enables, bit n-1 = phase n |

## Verification
The assertions hold on every cycle for the structural rules: no shoot-through on any phase, no more than one enable per side, stop clearing everything, the inhibit and the PWM gate holding the low side off, and illegal codes clearing the outputs. The bench scenarios are needed for the rest. These are the exact source/sink pairs of both direction tables, the three-edge latency of a direction change, and the current limit staying off through a whole PWM period after the trip input has already fallen.

// File: rtl/hc_pkg.sv
package hc_pkg;
    localparam int NUM_PH    = 3;
    localparam int HALL_W    = NUM_PH;
    localparam int SYNC_STG  = 2;

    typedef logic [NUM_PH-1:0] ph_vec_t;
    typedef logic [HALL_W-1:0] hall_t;

    typedef struct packed {
        logic    lim_cut;
        ph_vec_t hs;
        ph_vec_t ls;
    } drv_state_t;

    localparam drv_state_t DRV_RESET = '{lim_cut: 1'b0, hs: '0, ls: '0};
endpackage

// File: rtl/hc_dir_sync.sv
module hc_dir_sync #(
    parameter int STAGES = hc_pkg::SYNC_STG
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = async_in;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], async_in};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/hc_comm_table.sv
module hc_comm_table
    import hc_pkg::*;
(
    input  hall_t   hall,
    input  logic    rev,
    output ph_vec_t src,
    output ph_vec_t snk,
    output logic    illegal
);
    hall_t code;

    // Reverse rotation reuses the forward table on the complemented code.
    always_comb code = rev ? ~hall : hall;

    always_comb begin
        src     = '0;
        snk     = '0;
        illegal = 1'b0;
        unique case (code)
            3'b101: begin src = 3'b010; snk = 3'b001; end
            3'b100: begin src = 3'b100; snk = 3'b001; end
            3'b110: begin src = 3'b100; snk = 3'b010; end
            3'b010: begin src = 3'b001; snk = 3'b010; end
            3'b011: begin src = 3'b001; snk = 3'b100; end
            3'b001: begin src = 3'b010; snk = 3'b100; end
            default: illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/hc_chop.sv
module hc_chop
    import hc_pkg::*;
(
    input  ph_vec_t snk,
    input  logic    run_ok,
    input  logic    fault_inh,
    input  logic    pwm_gate,
    input  logic    ilim_active,
    input  logic    lim_cut_q,
    output logic    lim_cut_d,
    output ph_vec_t ls_d
);
    logic chop_on;

    // A trip holds for the rest of the period; a low gate starts a new one.
    always_comb lim_cut_d = pwm_gate & (lim_cut_q | ilim_active);

    always_comb chop_on = run_ok & ~fault_inh & pwm_gate & ~ilim_active & ~lim_cut_q;

    always_comb ls_d = chop_on ? snk : '0;
endmodule

// File: rtl/hall_commutator.sv
module hall_commutator
    import hc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] hall_lvl,
    input  logic       dir_rev,
    input  logic       stop_req,
    input  logic       fault_inh,
    input  logic       pwm_gate,
    input  logic       ilim_active,
    output logic [2:0] hs_en,
    output logic [2:0] ls_en
);
    drv_state_t st_d, st_q;

    logic    dir_s;
    ph_vec_t src, snk, ls_n;
    logic    illegal;
    logic    run_ok;
    logic    lim_n;

    hc_dir_sync #(.STAGES(SYNC_STG)) u_dir_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (dir_rev),
        .sync_out (dir_s)
    );

    hc_comm_table u_table (
        .hall    (hall_lvl),
        .rev     (dir_s),
        .src     (src),
        .snk     (snk),
        .illegal (illegal)
    );

    always_comb run_ok = ~stop_req & ~illegal;

    hc_chop u_chop (
        .snk         (snk),
        .run_ok      (run_ok),
        .fault_inh   (fault_inh),
        .pwm_gate    (pwm_gate),
        .ilim_active (ilim_active),
        .lim_cut_q   (st_q.lim_cut),
        .lim_cut_d   (lim_n),
        .ls_d        (ls_n)
    );

    always_comb begin
        st_d         = st_q;
        st_d.lim_cut = lim_n;
        st_d.hs      = run_ok ? src : '0;
        st_d.ls      = ls_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= DRV_RESET;
        else        st_q <= st_d;
    end

    assign hs_en = st_q.hs;
    assign ls_en = st_q.ls;
endmodule

// File: rtl/hall_commutator_chk.sv
module hall_commutator_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] hall_lvl,
    input logic       stop_req,
    input logic       fault_inh,
    input logic       pwm_gate,
    input logic       ilim_active,
    input logic [2:0] hs_en,
    input logic [2:0] ls_en
);
    a_r10_no_shoot_through: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_en & ls_en) == 3'b000);

    a_r3_one_per_side: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(hs_en) <= 1) && ($countones(ls_en) <= 1));

    a_r5_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> (hs_en == 3'b000 && ls_en == 3'b000));

    a_r6_fault_low_off: assert property (@(posedge clk) disable iff (!rst_n)
        fault_inh |=> (ls_en == 3'b000));

    a_r7_gate_low_off: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_gate |=> (ls_en == 3'b000));

    a_r8_trip_low_off: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_gate && ilim_active) |=> (ls_en == 3'b000));

    a_r4_illegal_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (hall_lvl == 3'b000 || hall_lvl == 3'b111) |=> (hs_en == 3'b000 && ls_en == 3'b000));
endmodule

bind hall_commutator hall_commutator_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .hall_lvl    (hall_lvl),
    .stop_req    (stop_req),
    .fault_inh   (fault_inh),
    .pwm_gate    (pwm_gate),
    .ilim_active (ilim_active),
    .hs_en       (hs_en),
    .ls_en       (ls_en)
);

// File: tb/hall_commutator_tb_top.sv
`timescale 1ns/1ps
module hall_commutator_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] hall_lvl = 3'b000;
    logic       dir_rev = 1'b0;
    logic       stop_req = 1'b1;
    logic       fault_inh = 1'b0;
    logic       pwm_gate = 1'b0;
    logic       ilim_active = 1'b0;
    logic [2:0] hs_en, ls_en;

    int errors = 0;
    int checks = 0;

    // model state
    logic m_d1 = 1'b0, m_d2 = 1'b0, m_lim = 1'b0;
    logic [2:0] e_hs, e_ls;

    always #2 clk = ~clk;

    hall_commutator dut_i (
        .clk(clk), .rst_n(rst_n), .hall_lvl(hall_lvl), .dir_rev(dir_rev),
        .stop_req(stop_req), .fault_inh(fault_inh), .pwm_gate(pwm_gate),
        .ilim_active(ilim_active), .hs_en(hs_en), .ls_en(ls_en)
    );

    function automatic logic [5:0] fwd_pair(input logic [2:0] c);
        case (c)
            3'b101: return {3'b010, 3'b001};
            3'b100: return {3'b100, 3'b001};
            3'b110: return {3'b100, 3'b010};
            3'b010: return {3'b001, 3'b010};
            3'b011: return {3'b001, 3'b100};
            3'b001: return {3'b010, 3'b100};
            default: return 6'b0;
        endcase
    endfunction

    task automatic check(input logic ok, input string req, input string what,
                         input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    function automatic string pick_tag(input logic [2:0] h, input logic d,
                                       input logic s, input logic f, input logic p,
                                       input logic l);
        if (s) return "R5";
        if (h == 3'b000 || h == 3'b111) return "R4";
        if (f) return "R6";
        if (!p) return "R7";
        if (l || m_lim) return "R8";
        return d ? "R2" : "R1";
    endfunction

    task automatic step(input logic [2:0] h, input logic d, input logic s,
                        input logic f, input logic p, input logic l, input string tag);
        logic [5:0] pr;
        string t;
        hall_lvl = h; dir_rev = d; stop_req = s; fault_inh = f;
        pwm_gate = p; ilim_active = l;
        t = (tag == "") ? pick_tag(h, m_d2, s, f, p, l) : tag;
        @(posedge clk);
        pr = fwd_pair(m_d2 ? ~h : h);
        e_hs = s ? 3'b000 : pr[5:3];
        e_ls = (s || f || !p || l || m_lim) ? 3'b000 : pr[2:0];
        m_lim = p & (m_lim | l);
        m_d2 = m_d1;
        m_d1 = d;
        @(negedge clk);
        check(hs_en == e_hs, t, "hs_en", hs_en, e_hs);
        check(ls_en == e_ls, t, "ls_en", ls_en, e_ls);
        check((hs_en & ls_en) == 3'b000, "R10", "hs&ls", hs_en & ls_en, 3'b000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [2:0] codes [6];
        codes = '{3'b101, 3'b100, 3'b110, 3'b010, 3'b011, 3'b001};
        void'($urandom(32'd1928));
        // R11 reset state
        repeat (3) @(negedge clk);
        hall_lvl = 3'b101; dir_rev = 1'b1; stop_req = 1'b0; pwm_gate = 1'b1;
        @(negedge clk);
        check(hs_en == 3'b000, "R11", "hs_en in reset", hs_en, 3'b000);
        check(ls_en == 3'b000, "R11", "ls_en in reset", ls_en, 3'b000);
        dir_rev = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // R1 full forward table, R3 exactly one per side
        for (int i = 0; i < 6; i++) begin
            step(codes[i], 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R1");
            check($countones(hs_en) == 1 && $countones(ls_en) == 1, "R3",
                  "one per side", hs_en | ls_en, 3'b111);
        end
        // R9 direction latency: hall 101 forward = ph2->ph1, reverse = ph1->ph2
        step(3'b101, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R9");
        check(hs_en == 3'b010, "R9", "edge1 still fwd", hs_en, 3'b010);
        step(3'b101, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R9");
        check(hs_en == 3'b010, "R9", "edge2 still fwd", hs_en, 3'b010);
        step(3'b101, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R9");
        check(hs_en == 3'b001 && ls_en == 3'b010, "R9", "edge3 reversed", hs_en, 3'b001);
        // R2 full reverse table
        for (int i = 0; i < 6; i++) step(codes[i], 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R2");
        // R4 illegal codes both directions
        step(3'b000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R4");
        step(3'b111, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R4");
        repeat (3) step(3'b110, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R1");
        step(3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R4");
        step(3'b111, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R4");
        // R5 stop
        step(3'b011, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R5");
        check(hs_en == 3'b000, "R5", "stop hs", hs_en, 3'b000);
        // R6 fault keeps high side (011 fwd -> src ph1)
        step(3'b011, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R6");
        check(hs_en == 3'b001 && ls_en == 3'b000, "R6", "fault hs kept", hs_en, 3'b001);
        // R7 gate low
        step(3'b011, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
        check(hs_en == 3'b001, "R7", "gate low hs kept", hs_en, 3'b001);
        // R8 trip holds until gate low
        step(3'b011, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R8");
        check(ls_en == 3'b100, "R8", "before trip", ls_en, 3'b100);
        step(3'b011, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R8");
        step(3'b011, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R8");
        check(ls_en == 3'b000, "R8", "held after trip fell", ls_en, 3'b000);
        step(3'b011, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R8");
        step(3'b011, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
        step(3'b011, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R8");
        check(ls_en == 3'b100, "R8", "new period restored", ls_en, 3'b100);

        // constrained random
        for (int n = 0; n < 3000; n++) begin
            logic [2:0] h;
            logic d, s, f, p, l;
            h = ($urandom_range(0, 9) == 0) ? (($urandom_range(0, 1) != 0) ? 3'b111 : 3'b000)
                                            : codes[$urandom_range(0, 5)];
            d = ($urandom_range(0, 19) == 0) ? ~dir_rev : dir_rev;
            s = ($urandom_range(0, 15) == 0);
            f = ($urandom_range(0, 11) == 0);
            p = ($urandom_range(0, 3) != 0);
            l = ($urandom_range(0, 9) == 0);
            step(h, d, s, f, p, l, "");
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule